// File: doc/BRIEF.md
# Auto-Incrementing Colour Palette Loader

This block holds a 256-entry colour lookup table. Red, green and blue are kept in three separate tables, each one byte wide. The host loads the table through two registers in a small register window. The first register sets the start index. The second accepts a stream of colour bytes. A hidden phase counter walks each byte through red, then green, then blue. When the blue byte of a triplet has been stored, the index moves to the next entry.

A host write to the data register can be one byte wide or one 32-bit word wide. A word is split into four colour bytes, most significant byte first. All four bytes go through the same three-phase walk, so a single word can end one triplet and start the next. While the bytes are being stored the block raises `busy`, and it ignores any host write during that time. A scanout pipeline drives the pixel port and gets a packed 0x00RRGGBB word one cycle later. A sticky flag tells the scanout side that the palette has changed and that the screen should be redrawn in full.

The loader runs as a two-state machine:
- **IDLE** waits for a host write. A write to the index register is handled in place and the machine stays in IDLE (transition *load_index*). A write to the data register loads the unpack register and moves to FEED (transition *start_feed*).
- **FEED** stores one byte per cycle. It stays in FEED while bytes remain (transition *next_byte*) and returns to IDLE after the last byte (transition *feed_done*).

Top module: `clut_loader`

## Requirements
- R1: A write to offset 0x0 (the index register) loads `bus_wdata[7:0]` as the palette index and sets the colour phase back to red. This holds even when a triplet is only partly written.
- R2: Colour bytes are stored according to the phase. Phase 0 stores to the red table, phase 1 to the green table and phase 2 to the blue table. After a blue byte is stored, the index increments and the phase returns to 0.
- R3: The index increments modulo 256, so a blue byte stored at entry 255 is followed by a red byte stored at entry 0.
- R4: A byte write to offset 0x4 (`bus_word`=0) supplies the colour byte `bus_wdata[7:0]`. `busy` is high for exactly one cycle after the write is accepted.
- R5: A word write to offset 0x4 (`bus_word`=1) supplies four colour bytes in the order [31:24], [23:16], [15:8], [7:0]. `busy` is high for exactly four cycles. The word may start at any phase.
- R6: A host write presented while `busy` is high is ignored. It does not change the palette, the index or the phase.
- R7: Pixel value p applied on `pix_in` yields `{8'h00, red[p], green[p], blue[p]}` on `rgb_out` one clock later.
- R8: `refresh_req` is set by any accepted write to the data register. It is cleared by a one-cycle `refresh_ack`. If a data write is accepted in the same cycle as `refresh_ack`, the flag stays set.
- R9: Reset clears all three tables to zero, sets the index and the phase to 0, drops `busy`, and raises `refresh_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 5 | Byte offset in the 32-byte register window |
| bus_word | input | 1 | 1 = 32-bit write, 0 = byte write |
| bus_wdata | input | 32 | Host write data |
| busy | output | 1 | Colour bytes are still being stored; host writes are ignored |
| pix_in | input | 8 | Pixel value to look up |
| rgb_out | output | 32 | Looked-up colour, 0x00RRGGBB |
| refresh_req | output | 1 | Palette changed; full redraw requested |
| refresh_ack | input | 1 | Scanout acknowledge; clears `refresh_req` |

## Verification
The hardest case to reach from the ports is a word write that starts partway through a triplet and crosses the index wrap. In that case the green and blue bytes of entry 255 and the red and green bytes of entry 0 all come from one bus word. The bench reaches it by writing index 255, then a single byte, then a word. It then reads both entries through the lookup port.

A second hard case is a write that arrives while `busy` is high. The bench sends an index write one cycle into a word feed. It then checks, through the lookups, that the feed continued as if that write had never happened.

A full sweep loads all 256 entries with arithmetic patterns using word writes. It then compares every entry against a model of the index and phase kept in the bench.

// File: rtl/clut_pkg.sv
package clut_pkg;
    parameter int IDX_W   = 8;
    parameter int COLOR_W = 8;
    parameter int BUS_W   = 32;
    parameter int ADDR_W  = 5;
    localparam int LANES  = BUS_W / COLOR_W;
    localparam int CNT_W  = $clog2(LANES + 1);
    localparam int DEPTH  = 1 << IDX_W;
    localparam int NCHAN  = 3;

    localparam logic [ADDR_W-1:0] OFS_INDEX = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 5'h04;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_FEED = 1'b1
    } feed_state_t;

    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } phase_t;
endpackage

// File: rtl/clut_bank.sv
module clut_bank
    import clut_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IDX_W-1:0]   waddr,
    input  logic [COLOR_W-1:0] wbyte,
    input  logic [IDX_W-1:0]   raddr,
    output logic [COLOR_W-1:0] rbyte
);
    logic [COLOR_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[waddr] <= wbyte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbyte <= '0;
        end else begin
            rbyte <= mem_q[raddr];
        end
    end
endmodule

// File: rtl/clut_sequencer.sv
module clut_sequencer
    import clut_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_word,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic               busy,
    output logic               data_accept,
    output logic [NCHAN-1:0]   tbl_we,
    output logic [IDX_W-1:0]   tbl_addr,
    output logic [COLOR_W-1:0] tbl_byte
);
    feed_state_t        state_q, state_d;
    phase_t             phase_q;
    logic [IDX_W-1:0]   index_q;
    logic [BUS_W-1:0]   shreg_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               accept, index_hit;

    assign accept      = bus_wr && (state_q == ST_IDLE);
    assign index_hit   = accept && (bus_addr == OFS_INDEX);
    assign data_accept = accept && (bus_addr == OFS_DATA);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: load_index / start_feed / next_byte / feed_done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (data_accept) state_d = ST_FEED;
            ST_FEED: if (cnt_q == CNT_W'(1)) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath: index, phase, unpack register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_RED;
            index_q <= '0;
            shreg_q <= '0;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (index_hit) begin
                        index_q <= bus_wdata[IDX_W-1:0];
                        phase_q <= PH_RED;
                    end else if (data_accept) begin
                        if (bus_word) begin
                            shreg_q <= bus_wdata;
                            cnt_q   <= CNT_W'(LANES);
                        end else begin
                            shreg_q <= {bus_wdata[COLOR_W-1:0], {(BUS_W-COLOR_W){1'b0}}};
                            cnt_q   <= CNT_W'(1);
                        end
                    end
                end
                ST_FEED: begin
                    shreg_q <= shreg_q << COLOR_W;
                    cnt_q   <= cnt_q - CNT_W'(1);
                    unique case (phase_q)
                        PH_RED:   phase_q <= PH_GREEN;
                        PH_GREEN: phase_q <= PH_BLUE;
                        default: begin
                            phase_q <= PH_RED;
                            index_q <= index_q + IDX_W'(1);
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy     = (state_q == ST_FEED);
        tbl_we   = '0;
        tbl_addr = index_q;
        tbl_byte = shreg_q[BUS_W-1 -: COLOR_W];
        if (state_q == ST_FEED) begin
            unique case (phase_q)
                PH_RED:   tbl_we = 3'b100;
                PH_GREEN: tbl_we = 3'b010;
                default:  tbl_we = 3'b001;
            endcase
        end
    end

    a_r1_phase_red_after_index: assert property (@(posedge clk) disable iff (!rst_n)
        index_hit |=> (phase_q == PH_RED && index_q == $past(bus_wdata[IDX_W-1:0])));

    a_r2_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q != 2'd3);

    a_r2_index_step_after_blue: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we[0] |=> (index_q == $past(index_q) + IDX_W'(1)));

    a_r5_feed_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q != '0 && cnt_q <= CNT_W'(LANES)));

    a_r6_busy_needs_data_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_wr && bus_addr == OFS_DATA));
endmodule

// File: rtl/clut_loader.sv
module clut_loader
    import clut_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic        bus_word,
    input  logic [31:0] bus_wdata,
    output logic        busy,
    input  logic [7:0]  pix_in,
    output logic [31:0] rgb_out,
    output logic        refresh_req,
    input  logic        refresh_ack
);
    logic [NCHAN-1:0]   tbl_we;
    logic [IDX_W-1:0]   tbl_addr;
    logic [COLOR_W-1:0] tbl_byte;
    logic [COLOR_W-1:0] chan_out [NCHAN];
    logic               data_accept;

    clut_sequencer u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_word    (bus_word),
        .bus_wdata   (bus_wdata),
        .busy        (busy),
        .data_accept (data_accept),
        .tbl_we      (tbl_we),
        .tbl_addr    (tbl_addr),
        .tbl_byte    (tbl_byte)
    );

    // channel 2 = red, 1 = green, 0 = blue
    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        clut_bank u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (tbl_we[c]),
            .waddr (tbl_addr),
            .wbyte (tbl_byte),
            .raddr (pix_in),
            .rbyte (chan_out[c])
        );
    end

    assign rgb_out = {{(32-NCHAN*COLOR_W){1'b0}}, chan_out[2], chan_out[1], chan_out[0]};

    always_ff @(posedge clk) begin
        if (!rst_n)           refresh_req <= 1'b1;
        else if (data_accept) refresh_req <= 1'b1;
        else if (refresh_ack) refresh_req <= 1'b0;
    end

    a_r2_one_table_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tbl_we));

    a_r6_no_table_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tbl_we == '0));

    a_r8_set_on_data_write: assert property (@(posedge clk) disable iff (!rst_n)
        data_accept |=> refresh_req);

    a_r8_clear_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_ack && !data_accept) |=> !refresh_req);

    a_r7_upper_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rgb_out[31:24] == 8'h00);
endmodule

// File: tb/clut_loader_test.sv
`timescale 1ns/1ps
module clut_loader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_word = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        busy;
    logic [7:0]  pix_in = '0;
    logic [31:0] rgb_out;
    logic        refresh_req;
    logic        refresh_ack = 1'b0;

    int checks = 0;
    int fails  = 0;

    logic [7:0] m_r [256];
    logic [7:0] m_g [256];
    logic [7:0] m_b [256];
    logic [7:0] m_idx;
    int         m_ph;

    always #2.5 clk = ~clk;

    clut_loader uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .busy(busy),
        .pix_in(pix_in), .rgb_out(rgb_out), .refresh_req(refresh_req),
        .refresh_ack(refresh_ack)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic model_byte(input logic [7:0] b);
        case (m_ph)
            0: begin m_r[m_idx] = b; m_ph = 1; end
            1: begin m_g[m_idx] = b; m_ph = 2; end
            default: begin m_b[m_idx] = b; m_ph = 0; m_idx = m_idx + 8'd1; end
        endcase
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d, input logic w,
                             output int busy_cycles);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_word = w;
        @(negedge clk);
        bus_wr = 1'b0;
        busy_cycles = 0;
        while (busy) begin
            busy_cycles++;
            @(negedge clk);
        end
        if (a == 5'h00) begin
            m_idx = d[7:0]; m_ph = 0;
        end else if (w) begin
            for (int k = 3; k >= 0; k--) model_byte(d[8*k +: 8]);
        end else begin
            model_byte(d[7:0]);
        end
    endtask

    task automatic look(input string req, input int p);
        @(negedge clk);
        pix_in = p[7:0];
        @(negedge clk);
        chk(req, rgb_out, {8'h00, m_r[p], m_g[p], m_b[p]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R5 watchdog: actual run still active, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int bc;
        logic [7:0] stream [768];
        for (int i = 0; i < 256; i++) begin
            m_r[i] = '0; m_g[i] = '0; m_b[i] = '0;
        end
        m_idx = '0; m_ph = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        chk("R9 refresh after reset", {31'b0, refresh_req}, 32'd1);
        chk("R9 busy after reset", {31'b0, busy}, 32'd0);
        look("R9 entry 0 clear", 0);
        look("R9 entry 255 clear", 255);
        // R9: phase 0 and index 0 after reset -> first byte lands in red[0]
        bus_write(5'h04, 32'h0000_00C3, 1'b0, bc);
        chk("R4 byte write busy cycles", bc, 32'd1);
        look("R9 first byte to red of entry 0", 0);

        // R8: ack clears, ack together with write keeps set
        @(negedge clk); refresh_ack = 1'b1;
        @(negedge clk); refresh_ack = 1'b0;
        chk("R8 ack clears flag", {31'b0, refresh_req}, 32'd0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 5'h04; bus_word = 1'b0; bus_wdata = 32'h11; refresh_ack = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; refresh_ack = 1'b0;
        model_byte(8'h11);
        while (busy) @(negedge clk);
        chk("R8 set wins over ack", {31'b0, refresh_req}, 32'd1);

        // R1/R2/R5: full sweep with word writes from index 0
        for (int i = 0; i < 256; i++) begin
            stream[3*i]   = 8'(i) ^ 8'h5A;
            stream[3*i+1] = 8'(i * 3 + 7);
            stream[3*i+2] = ~8'(i);
        end
        bus_write(5'h00, 32'h0000_0000, 1'b0, bc);
        chk("R1 index write no busy", bc, 32'd0);
        for (int w = 0; w < 192; w++) begin
            bus_write(5'h04, {stream[4*w], stream[4*w+1], stream[4*w+2], stream[4*w+3]}, 1'b1, bc);
            if (w == 0) chk("R5 word write busy cycles", bc, 32'd4);
        end
        for (int p = 0; p < 256; p++) look("R2 R5 R7 sweep entry", p);

        // R3 + R5: index 255, one byte, then a word straddling the wrap
        bus_write(5'h00, 32'h0000_00FF, 1'b0, bc);
        bus_write(5'h04, 32'h0000_00A1, 1'b0, bc);
        bus_write(5'h04, 32'hB2C3_D4E5, 1'b1, bc);
        chk("R3 entry 255 after wrap", {8'h0, m_r[255], m_g[255], m_b[255]}, 32'h00A1_B2C3);
        look("R3 entry 255 via lookup", 255);
        look("R3 wrap red green of entry 0", 0);
        chk("R3 model entry 0", {8'h0, m_r[0], m_g[0]}, 32'h0000_D4E5);

        // R1: index write mid-triplet forces phase back to red
        bus_write(5'h00, 32'h0000_000A, 1'b0, bc);
        bus_write(5'h04, 32'h0000_0077, 1'b0, bc);
        bus_write(5'h00, 32'h0000_000A, 1'b0, bc);
        bus_write(5'h04, 32'h0000_0088, 1'b0, bc);
        look("R1 phase reset puts byte in red again", 10);
        chk("R1 red of entry 10", {24'h0, m_r[10]}, 32'h88);

        // R6: write during busy is ignored
        bus_write(5'h00, 32'h0000_0040, 1'b0, bc);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 5'h04; bus_word = 1'b1; bus_wdata = 32'h0102_0304;
        @(negedge clk);
        bus_addr = 5'h00; bus_word = 1'b0; bus_wdata = 32'h0000_0090;
        @(negedge clk);
        bus_wr = 1'b0;
        while (busy) @(negedge clk);
        for (int k = 3; k >= 0; k--) model_byte(8'(32'h0102_0304 >> (8*k)));
        bus_write(5'h04, 32'h0000_0005, 1'b0, bc);
        look("R6 entry 64 unaffected by dropped write", 64);
        look("R6 entry 65 continues sequence", 65);
        look("R6 entry 144 untouched", 144);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule